// File: doc/BRIEF.md
# Error-Tagged Receive Queue

This block sits behind a serial receiver and buffers the characters it decodes. Each stored entry keeps its data byte together with three error tags: parity, framing and overrun. The tags travel down the queue with their byte. The entry at the head is presented at all times. Its tags appear on three status flags, so software can inspect them before it pops that entry. A service request goes up once enough characters are waiting. The DMA request follows it, unless an error lies near the head of the queue.

A small state machine gates DMA. It has three states. In `ST_FLOW`, DMA is allowed. In `ST_ERR_HOLD`, an errored entry sits among the four oldest entries. In `ST_WAIT_CLR`, the errored entries have been popped but software has not yet acknowledged them. The transitions are:
- `T_ERR_SEEN`: `ST_FLOW` to `ST_ERR_HOLD` when the error window becomes non-clean.
- `T_FLUSHED`: `ST_ERR_HOLD` to `ST_WAIT_CLR` when the window is clean again.
- `T_ACKED`: `ST_WAIT_CLR` to `ST_FLOW` on a status-clear strobe while the window is clean.
- `T_REERR`: `ST_WAIT_CLR` back to `ST_ERR_HOLD` when a new error enters the window.

The error interrupt is high in every state other than `ST_FLOW`.

A separate idle timer counts frame-time ticks while the queue holds data. When three ticks pass with no arrival and no pop, it raises a receiver-idle interrupt.

Top module: `rxq_tagged_fifo`

## Requirements
- R1: A pushed byte and its parity (bit `in_perr`) and framing (bit `in_ferr`) tags come out in arrival order: `rd_data` and the flags show the head entry, and one pop per `rd_en` pulse advances to the next.
- R2: With no error pending, `svc_req` and `dma_req` are both high exactly when 4 or more of the 12 entries are occupied.
- R3: A frame that arrives while all 12 entries are full is discarded and the occupancy is unchanged. The overrun tag of the newest stored entry is set and is seen on `flag_ovr` when that entry reaches the head.
- R4: When any of the four oldest entries carries a tag, `dma_req` is low in that same cycle, and `err_irq` rises on the following clock edge.
- R5: After the errored entries have been popped, `err_irq` stays high and `dma_req` stays low until `sts_clr` is pulsed. A `sts_clr` pulse while an errored entry is still in the window has no effect.
- R6: The three flags equal the tags of the current head entry, and they are all zero when the queue is empty.
- R7: `idle_irq` rises on the edge that takes the third `frame_tick` with no frame and no pop while data is held. A frame or a pop clears it. It never asserts while the queue is empty.
- R8: Pulsing `rd_en` on an empty queue returns zero data and zero flags and leaves the queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | One-cycle strobe: a decoded frame is present |
| in_data | input | 8 | Decoded character |
| in_perr | input | 1 | Parity error tag of the frame |
| in_ferr | input | 1 | Framing error tag of the frame |
| rd_en | input | 1 | Pop the head entry |
| sts_clr | input | 1 | Acknowledge the error status |
| frame_tick | input | 1 | One pulse per frame time |
| rd_data | output | 8 | Head entry data, zero when empty |
| flag_perr | output | 1 | Parity tag of head entry |
| flag_ferr | output | 1 | Framing tag of head entry |
| flag_ovr | output | 1 | Overrun tag of head entry |
| svc_req | output | 1 | Occupancy at or above threshold |
| dma_req | output | 1 | Service request while no error is pending |
| err_irq | output | 1 | Error interrupt |
| idle_irq | output | 1 | Receiver idle interrupt |

## Verification
The hardest condition to reach from the ports is the `ST_WAIT_CLR` state while the queue also holds enough data to request service. In that state, only the missing acknowledgement keeps DMA off. The stimulus places one tagged entry behind six clean ones and pops until the entry enters the four-entry window. It issues an early clear that must be ignored, pops past the errored entry, and refills to the threshold. Only then does it pulse the clear. The overrun path is reached by first sweeping the fill level from empty to full, which checks the threshold at every occupancy on the way.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    typedef struct packed {
        logic       ovr;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        ST_FLOW     = 2'd0,
        ST_ERR_HOLD = 2'd1,
        ST_WAIT_CLR = 2'd2
    } gate_state_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 12,
    parameter int WIN   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_req,
    input  rxq_entry_t wr_entry,
    input  logic       rd_req,
    output rxq_entry_t head,
    output logic       empty,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic       win_err,
    output logic       rd_pop
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    rxq_entry_t        mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, last_ptr;
    logic [CNT_W-1:0]  count;
    logic              full, push, drop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full     = (count == CNT_W'(DEPTH));
    assign empty    = (count == '0);
    assign push     = wr_req && !full;
    assign drop     = wr_req && full;
    assign rd_pop   = rd_req && !empty;
    assign last_ptr = (wr_ptr == '0) ? PTR_W'(DEPTH-1) : wr_ptr - 1'b1;
    assign head     = empty ? '0 : mem[rd_ptr];
    assign level    = count;

    always_comb begin
        win_err = 1'b0;
        for (int i = 0; i < WIN; i++) begin
            int idx;
            idx = int'(rd_ptr) + i;
            if (idx >= DEPTH) idx = idx - DEPTH;
            if (CNT_W'(i) < count) begin
                if (mem[idx].perr || mem[idx].ferr || mem[idx].ovr) win_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= wr_entry;
                wr_ptr      <= bump(wr_ptr);
            end
            if (drop) mem[last_ptr].ovr <= 1'b1;
            if (rd_pop) rd_ptr <= bump(rd_ptr);
            case ({push, rd_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    p_drop_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !rd_pop) |=> $stable(count));
    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && empty && !wr_req) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/rxq_err_gate.sv
module rxq_err_gate
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_err,
    input  logic sts_clr,
    output logic dma_ok,
    output logic err_irq
);
    gate_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_FLOW;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FLOW:     if (win_err) state_nx = ST_ERR_HOLD;         // T_ERR_SEEN
            ST_ERR_HOLD: if (!win_err) state_nx = ST_WAIT_CLR;        // T_FLUSHED
            ST_WAIT_CLR: begin
                if (win_err)      state_nx = ST_ERR_HOLD;             // T_REERR
                else if (sts_clr) state_nx = ST_FLOW;                 // T_ACKED
            end
            default:     state_nx = ST_FLOW;
        endcase
    end

    always_comb begin
        dma_ok  = (state == ST_FLOW) && !win_err;
        err_irq = (state != ST_FLOW);
    end

    p_err_raise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        win_err |=> err_irq);
    p_hold_until_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT_CLR && !sts_clr && !win_err) |=> (state == ST_WAIT_CLR));
    p_clear_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERR_HOLD && win_err) |=> err_irq);
endmodule

// File: rtl/rxq_idle_timer.sv
module rxq_idle_timer #(
    parameter int IDLE_FRAMES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    input  logic empty,
    input  logic frame_tick,
    output logic idle_irq
);
    localparam int CW = $clog2(IDLE_FRAMES+1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (activity || empty) cnt <= '0;
        else if (frame_tick && cnt != CW'(IDLE_FRAMES)) cnt <= cnt + 1'b1;
    end

    assign idle_irq = (cnt == CW'(IDLE_FRAMES));

    p_idle_quiet_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> !idle_irq);
    p_idle_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
        activity |=> !idle_irq);
endmodule

// File: rtl/rxq_tagged_fifo.sv
module rxq_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH       = 12,
    parameter int WIN         = 4,
    parameter int SVC_LEVEL   = 4,
    parameter int IDLE_FRAMES = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_perr,
    input  logic       in_ferr,
    input  logic       rd_en,
    input  logic       sts_clr,
    input  logic       frame_tick,
    output logic [7:0] rd_data,
    output logic       flag_perr,
    output logic       flag_ferr,
    output logic       flag_ovr,
    output logic       svc_req,
    output logic       dma_req,
    output logic       err_irq,
    output logic       idle_irq
);
    localparam int CNT_W = $clog2(DEPTH+1);

    rxq_entry_t       wr_entry, head;
    logic             empty, win_err, rd_pop, dma_ok;
    logic [CNT_W-1:0] level;

    always_comb begin
        wr_entry      = '0;
        wr_entry.data = in_data;
        wr_entry.perr = in_perr;
        wr_entry.ferr = in_ferr;
    end

    rxq_store #(.DEPTH(DEPTH), .WIN(WIN)) store_i (
        .clk(clk), .rst_n(rst_n), .wr_req(in_valid), .wr_entry(wr_entry),
        .rd_req(rd_en), .head(head), .empty(empty), .level(level),
        .win_err(win_err), .rd_pop(rd_pop)
    );

    rxq_err_gate gate_i (
        .clk(clk), .rst_n(rst_n), .win_err(win_err), .sts_clr(sts_clr),
        .dma_ok(dma_ok), .err_irq(err_irq)
    );

    rxq_idle_timer #(.IDLE_FRAMES(IDLE_FRAMES)) idle_i (
        .clk(clk), .rst_n(rst_n), .activity(in_valid || rd_pop),
        .empty(empty), .frame_tick(frame_tick), .idle_irq(idle_irq)
    );

    assign rd_data   = head.data;
    assign flag_perr = head.perr;
    assign flag_ferr = head.ferr;
    assign flag_ovr  = head.ovr;
    assign svc_req   = (level >= CNT_W'(SVC_LEVEL));
    assign dma_req   = svc_req && dma_ok;

    p_dma_needs_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dma_req) |-> (level >= CNT_W'(SVC_LEVEL)));
    p_dma_off_in_error_r4: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> !dma_req);
    p_empty_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (rd_data == 8'h00 && !flag_perr && !flag_ferr && !flag_ovr));
endmodule

// File: tb/rxq_tagged_fifo_tb_top.sv
module rxq_tagged_fifo_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_perr = 1'b0, in_ferr = 1'b0;
    logic [7:0] in_data = '0;
    logic       rd_en = 1'b0, sts_clr = 1'b0, frame_tick = 1'b0;
    logic [7:0] rd_data;
    logic       flag_perr, flag_ferr, flag_ovr, svc_req, dma_req, err_irq, idle_irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #10 clk = ~clk;

    rxq_tagged_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_perr(in_perr), .in_ferr(in_ferr), .rd_en(rd_en), .sts_clr(sts_clr),
        .frame_tick(frame_tick), .rd_data(rd_data), .flag_perr(flag_perr),
        .flag_ferr(flag_ferr), .flag_ovr(flag_ovr), .svc_req(svc_req),
        .dma_req(dma_req), .err_irq(err_irq), .idle_irq(idle_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic p, input logic f);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_perr = p; in_ferr = f;
        @(negedge clk);
        in_valid = 1'b0; in_perr = 1'b0; in_ferr = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); sts_clr = 1'b1;
        @(negedge clk); sts_clr = 1'b0;
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R6 reset data", int'(rd_data), 0);
        chk("R2 reset svc", int'(svc_req), 0);
        chk("R4 reset err", int'(err_irq), 0);
        chk("R7 reset idle", int'(idle_irq), 0);

        // R8: empty read
        pop();
        chk("R8 empty read data", int'(rd_data), 0);
        chk("R8 empty read flags", int'({flag_perr, flag_ferr, flag_ovr}), 0);
        chk("R8 empty stays low", int'(svc_req), 0);

        // R2: sweep fill 1..12
        for (int n = 1; n <= 12; n++) begin
            push(pat(n), 1'b0, 1'b0);
            @(negedge clk);
            chk("R2 svc at fill", int'(svc_req), (n >= 4) ? 1 : 0);
            chk("R2 dma at fill", int'(dma_req), (n >= 4) ? 1 : 0);
        end
        // R3: overflow frame dropped
        push(8'hEE, 1'b0, 1'b0);
        @(negedge clk);
        // draining 12 in order; overflow tag lands on the 12th
        for (int n = 1; n <= 12; n++) begin
            chk("R1 order data", int'(rd_data), int'(pat(n)));
            chk("R3 ovr tag", int'(flag_ovr), (n == 12) ? 1 : 0);
            if (n == 12) begin
                chk("R4 err on ovr head", int'(err_irq), 1);
            end
            pop();
            @(negedge clk);
            chk("R2 svc on drain", int'(svc_req), (12 - n >= 4) ? 1 : 0);
        end
        chk("R3 dropped frame absent", int'(rd_data), 0);
        clr();
        @(negedge clk);
        chk("R5 cleared after flush", int'(err_irq), 0);

        // R1/R6: tag transport
        for (int i = 0; i < 4; i++) push(pat(i + 40), i[0], i[1]);
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            chk("R6 perr flag", int'(flag_perr), int'(i[0]));
            chk("R6 ferr flag", int'(flag_ferr), int'(i[1]));
            chk("R1 tagged data", int'(rd_data), int'(pat(i + 40)));
            pop();
        end
        @(negedge clk);
        chk("R6 flags empty", int'({flag_perr, flag_ferr, flag_ovr}), 0);
        clr();
        @(negedge clk);
        chk("R5 ack returns flow", int'(err_irq), 0);

        // R4/R5: error entering the window
        for (int i = 0; i < 6; i++) push(pat(i + 60), 1'b0, 1'b0);
        push(8'hA5, 1'b1, 1'b0);
        @(negedge clk);
        chk("R4 error outside window", int'(err_irq), 0);
        chk("R2 dma with 7 clean-window", int'(dma_req), 1);
        pop(); pop();
        @(negedge clk);
        chk("R4 still outside window", int'(err_irq), 0);
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk("R4 dma drops same cycle", int'(dma_req), 0);
        @(negedge clk);
        chk("R4 err raised", int'(err_irq), 1);
        clr();
        @(negedge clk);
        chk("R5 early clear ignored", int'(err_irq), 1);
        pop(); pop(); pop();
        @(negedge clk);
        chk("R6 errored head perr", int'(flag_perr), 1);
        chk("R1 errored head data", int'(rd_data), 8'hA5);
        pop();
        for (int i = 0; i < 5; i++) push(pat(i + 80), 1'b0, 1'b0);
        @(negedge clk);
        chk("R5 svc but held", int'(svc_req), 1);
        chk("R5 dma held before ack", int'(dma_req), 0);
        chk("R5 err held before ack", int'(err_irq), 1);
        clr();
        @(negedge clk);
        chk("R5 err cleared", int'(err_irq), 0);
        chk("R5 dma resumes", int'(dma_req), 1);
        for (int i = 0; i < 5; i++) pop();

        // R7: idle timer
        @(negedge clk);
        tick(); tick(); tick();
        chk("R7 no idle when empty", int'(idle_irq), 0);
        push(8'h11, 1'b0, 1'b0);
        tick(); tick();
        chk("R7 two ticks", int'(idle_irq), 0);
        tick();
        chk("R7 third tick", int'(idle_irq), 1);
        push(8'h22, 1'b0, 1'b0);
        chk("R7 frame clears", int'(idle_irq), 0);
        tick(); tick(); tick();
        chk("R7 idle again", int'(idle_irq), 1);
        pop();
        chk("R7 pop clears", int'(idle_irq), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule